// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (two-wire bus, block access)

This block is a two-wire serial bus slave that holds the configuration bytes of a multi-output clock generator. A host writes the bank in one sequential burst: after the write address it must send a command byte and a byte count. Both are acknowledged and thrown away. The data bytes that follow land in register 0, then 1, and so on upward. A read at the companion address returns a byte count of 8, then the whole bank from register 0. There is no register pointer. The host can end a write after any complete byte, and the registers it did not reach keep their values.

When power-on reset ends, the block captures five strap inputs once: four frequency-select straps and one mode strap. The inverted strap values show up in read-only bits of the bank. The bank drives decoded control fields to the clock gating logic. These fields are the frequency code (taken from the straps or from register bits), spread-spectrum enable, a global output-off control, and the selection of which output groups the external stop input gates. The raw bytes are also presented in parallel so that the per-output enable bits can be wired to the gates.

The bus lines are sampled by the system clock through a two-stage synchronizer. START and STOP are recognised as SDA edges while SCL is high. SDA is open-drain and is modelled as an input plus a pull-low enable. The bus has its own flow control, the acknowledge bit. The parallel outputs are plain levels with no handshake.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), i.e. the 7-bit address 0x69 followed by the direction bit. Any other address gets no acknowledge, and the transfer changes no register.
- R2: In a write, the first two bytes after the address are acknowledged and their values have no effect on any register.
- R3: Write data bytes are acknowledged one by one and load register 0, 1, 2, … in ascending order. A STOP after any complete byte leaves the higher registers unchanged. Registers change only through such writes.
- R4: A write that carries more data bytes than there are registers (8) acknowledges the extra bytes and drops them.
- R5: A read returns the byte 0x08 first, then registers 0 through 7, each MSB first. The host acknowledges each byte, and a not-acknowledge ends the transfer.
- R6: The power-on values are: register 0 = 0x00, the writable bits of registers 1–3 all 1, register 4 = 0x7F, register 5 = 0xFF, register 6 = 0x07, register 7 = 0x00.
- R7: The straps are sampled on the first clock after reset is released (strap[3:0] = frequency select fs3..fs0, strap[4] = mode). Later strap changes have no effect. `mode_o` presents the captured mode strap.
- R8: Read-only bits return inverted straps: register 1 bit 7 = ~mode, register 2 bit 7 = ~fs3, register 3 bits 7/6/5 = ~fs0/~fs1/~fs2. Writes to these bits are ignored.
- R9: When register 0 bit 3 is 0, `freq_code_o` = {0, fs3, fs2, fs1, fs0} from the straps. When it is 1, `freq_code_o` = {bit 2, bit 7, bit 6, bit 5, bit 4} of register 0.
- R10: `spread_en_o` follows register 0 bit 1, and `outputs_off_o` follows register 0 bit 0.
- R11: Register 4 bits 7:6 select what the stop input gates: 00 nothing, 01 SDRAM and AGP groups, 10 SDRAM group only, 11 AGP group only. The result is shown on `stop_sdram_o` and `stop_agp_o`.
- R12: The slave changes its SDA pull only while the synchronized SCL is low, and it releases SDA on STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 5 | Strap levels: [3:0] frequency select, [4] mode |
| regs_o | output | 64 | Register bank as read back, register n at bits 8n+7:8n |
| freq_code_o | output | 5 | Selected frequency code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| outputs_off_o | output | 1 | Tristate all clock outputs |
| stop_sdram_o | output | 1 | Stop input gates the SDRAM group |
| stop_agp_o | output | 1 | Stop input gates the AGP group |
| mode_o | output | 1 | Captured mode strap |

## Verification
The assertions assume a bus master that keeps each SCL level for longer than the synchronizer delay. They also assume the master moves SDA only while SCL is low, except when it forms START and STOP, and that it never issues STOP while the slave is pulling SDA. The bench's master builds every bit from quarter periods of ten system clocks. It changes SDA only in the middle of a low SCL phase, releases SDA during every acknowledge slot owned by the slave, and sends STOP only after a completed byte and its acknowledge. Straps are held stable across reset release and changed only afterwards.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } bus_state_e;

  // power-on contents of register n (writable bits only matter)
  function automatic logic [7:0] reg_default(input int unsigned n);
    case (n)
      0:       return 8'h00;
      4:       return 8'h7F;
      6:       return 8'h07;
      7:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // bits of register n that a bus write may change
  function automatic logic [7:0] wr_mask(input int unsigned n);
    case (n)
      1, 2:    return 8'h7F;
      3:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // read-only strap readback bits of register n (inverted straps)
  function automatic logic [7:0] strap_bits(input int unsigned n, input logic [4:0] s);
    case (n)
      1:       return {~s[4], 7'b0};
      2:       return {~s[3], 7'b0};
      3:       return {~s[0], ~s[1], ~s[2], 5'b0};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_block_engine.sv
module i2c_block_engine
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS),
  localparam int unsigned CNT_W   = $clog2(NUM_REGS + 3)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [8*NUM_REGS-1:0]    rd_data,
  output logic                     sda_pull_o,
  output logic                     wr_stb_o,
  output logic [RIDX_W-1:0]        wr_idx_o,
  output logic [7:0]               wr_data_o
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(NUM_REGS + 2);
  localparam logic [CNT_W-1:0] HDR = CNT_W'(2);

  bus_state_e       state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       txsh;
  logic             is_addr;
  logic             rd_mode;
  logic [CNT_W-1:0] byte_idx;
  logic [7:0]       tx_next;

  // byte 0 of a read is the count, then registers in order, then all ones
  always_comb begin
    tx_next = 8'hFF;
    if (byte_idx == '0) tx_next = 8'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (byte_idx == CNT_W'(i + 1)) tx_next = rd_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txsh       <= '1;
      is_addr    <= 1'b0;
      rd_mode    <= 1'b0;
      byte_idx   <= '0;
      sda_pull_o <= 1'b0;
      wr_stb_o   <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_det) begin
        state      <= ST_RX;
        is_addr    <= 1'b1;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (is_addr) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rd_mode    <= shreg[0];
                  byte_idx   <= '0;
                  sda_pull_o <= 1'b1;
                  state      <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_pull_o <= 1'b1;
                state      <= ST_ACK;
                if (byte_idx >= HDR && byte_idx < SAT) begin
                  wr_stb_o  <= 1'b1;
                  wr_idx_o  <= RIDX_W'(byte_idx - HDR);
                  wr_data_o <= shreg;
                end
                if (byte_idx < SAT) byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              bitcnt  <= '0;
              if (rd_mode) begin
                txsh       <= tx_next;
                sda_pull_o <= ~tx_next[7];
                state      <= ST_TX;
                if (byte_idx < SAT) byte_idx <= byte_idx + 1'b1;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                state      <= ST_TXACK;
              end else begin
                txsh       <= {txsh[6:0], 1'b1};
                sda_pull_o <= ~txsh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              state <= sda_s ? ST_IDLE : ST_ACK;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned STRAPS   = 5,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STRAPS-1:0]     strap_i,
  input  logic                  wr_stb,
  input  logic [RIDX_W-1:0]     wr_idx,
  input  logic [7:0]            wr_data,
  output logic [8*NUM_REGS-1:0] rd_data,
  output logic [STRAPS-1:0]     strap_q,
  output logic                  strap_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_i;
      strap_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(g);
    logic [7:0] store;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store <= reg_default(g) & MASK;
      end else if (wr_stb && wr_idx == RIDX_W'(g)) begin
        store <= wr_data & MASK;
      end
    end
    assign rd_data[8*g +: 8] = store | strap_bits(g, strap_q);
  end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [4:0]            strap_i,
  output logic [8*NUM_REGS-1:0] regs_o,
  output logic [4:0]            freq_code_o,
  output logic                  spread_en_o,
  output logic                  outputs_off_o,
  output logic                  stop_sdram_o,
  output logic                  stop_agp_o,
  output logic                  mode_o
);

  localparam int unsigned RIDX_W = $clog2(NUM_REGS);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb;
  logic [RIDX_W-1:0] wr_idx;
  logic [7:0]        wr_data;
  logic [4:0]        strap_q;
  logic              strap_done;
  logic [7:0]        cfg0;
  logic [1:0]        stop_sel;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_block_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rd_data    (regs_o),
    .sda_pull_o (sda_pull_o),
    .wr_stb_o   (wr_stb),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  clkcfg_regfile #(.NUM_REGS(NUM_REGS), .STRAPS(5)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_i    (strap_i),
    .wr_stb     (wr_stb),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_data    (regs_o),
    .strap_q    (strap_q),
    .strap_done (strap_done)
  );

  assign cfg0          = regs_o[7:0];
  assign freq_code_o   = cfg0[3] ? {cfg0[2], cfg0[7:4]} : {1'b0, strap_q[3:0]};
  assign spread_en_o   = cfg0[1];
  assign outputs_off_o = cfg0[0];
  assign mode_o        = strap_q[4];
  assign stop_sel      = regs_o[39:38];
  assign stop_sdram_o  = (stop_sel == 2'b01) || (stop_sel == 2'b10);
  assign stop_agp_o    = (stop_sel == 2'b01) || (stop_sel == 2'b11);

endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk #(
  parameter int unsigned NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_pull_o,
  input logic                  stop_det,
  input logic                  wr_stb,
  input logic                  strap_done,
  input logic [8*NUM_REGS-1:0] regs_o,
  input logic [4:0]            freq_code_o,
  input logic                  mode_o
);

  p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

  p_release_on_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && strap_done) |=> $stable(regs_o));

  p_freq_strap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && !regs_o[3]) |->
      freq_code_o == {1'b0, ~regs_o[23], ~regs_o[29], ~regs_o[30], ~regs_o[31]});

  p_mode_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |-> (mode_o == ~regs_o[15]));

  p_strap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(mode_o));

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .sda_pull_o  (sda_pull_o),
  .stop_det    (stop_det),
  .wr_stb      (wr_stb),
  .strap_done  (strap_done),
  .regs_o      (regs_o),
  .freq_code_o (freq_code_o),
  .mode_o      (mode_o)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb;

  localparam int Q  = 10;
  localparam int WD = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [4:0]  strap_i = 5'b10110;
  logic        sda_pull_o;
  logic [63:0] regs_o;
  logic [4:0]  freq_code_o;
  logic        spread_en_o, outputs_off_o, stop_sdram_o, stop_agp_o, mode_o;
  wire         sda_w = m_sda & ~sda_pull_o;

  int          checks = 0;
  int          errors = 0;
  bit          cmp_en = 1'b0;
  bit          done = 1'b0;
  logic [7:0]  m_store [0:7];
  logic [4:0]  strap_cap = 5'b10110;
  logic [7:0]  wdata [0:15];

  always #4 clk = ~clk;

  clkcfg_i2c_slave u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (sda_w),
    .sda_pull_o    (sda_pull_o),
    .strap_i       (strap_i),
    .regs_o        (regs_o),
    .freq_code_o   (freq_code_o),
    .spread_en_o   (spread_en_o),
    .outputs_off_o (outputs_off_o),
    .stop_sdram_o  (stop_sdram_o),
    .stop_agp_o    (stop_agp_o),
    .mode_o        (mode_o)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] bmask(input int n);
    if (n == 1 || n == 2) return 8'h7F;
    if (n == 3) return 8'h1F;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_byte(input int n);
    logic [7:0] v;
    v = m_store[n] & bmask(n);
    if (n == 1) v[7] = ~strap_cap[4];
    if (n == 2) v[7] = ~strap_cap[3];
    if (n == 3) begin
      v[7] = ~strap_cap[0];
      v[6] = ~strap_cap[1];
      v[5] = ~strap_cap[2];
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_regs();
    logic [63:0] r;
    for (int n = 0; n < 8; n++) r[8*n +: 8] = exp_byte(n);
    return r;
  endfunction

  function automatic logic [4:0] exp_freq();
    logic [7:0] b;
    b = exp_byte(0);
    if (b[3]) return {b[2], b[7], b[6], b[5], b[4]};
    return {1'b0, strap_cap[3], strap_cap[2], strap_cap[1], strap_cap[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [1:0] sel;
      sel = exp_byte(4)[7:6];
      chk(regs_o == exp_regs(), "R3/R6/R8", "register bank", regs_o, exp_regs());
      chk(freq_code_o == exp_freq(), "R9", "freq code", 64'(freq_code_o), 64'(exp_freq()));
      chk(spread_en_o == exp_byte(0)[1], "R10", "spread enable", 64'(spread_en_o), 64'(exp_byte(0)[1]));
      chk(outputs_off_o == exp_byte(0)[0], "R10", "outputs off", 64'(outputs_off_o), 64'(exp_byte(0)[0]));
      chk(stop_sdram_o == (sel == 2'd1 || sel == 2'd2), "R11", "stop sdram",
          64'(stop_sdram_o), 64'(sel == 2'd1 || sel == 2'd2));
      chk(stop_agp_o == (sel == 2'd1 || sel == 2'd3), "R11", "stop agp",
          64'(stop_agp_o), 64'(sel == 2'd1 || sel == 2'd3));
      chk(mode_o == strap_cap[4], "R7", "mode strap", 64'(mode_o), 64'(strap_cap[4]));
      chk(!sda_pull_o, "R12", "bus released when idle", 64'(sda_pull_o), 64'd0);
    end
  end

  // ---------------- bus master ----------------
  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_window();
    wq(4);
    cmp_en = 1'b1;
    wq(16);
    cmp_en = 1'b0;
  endtask

  task automatic i2c_start();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    @(negedge clk);
    ack = ~sda_w;
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q);
      @(negedge clk);
      b[i] = sda_w;
      wq(Q);
      m_scl = 1'b0;
    end
    wq(Q);
    m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  task automatic write_txn(input logic [7:0] cmd, input logic [7:0] cnt, input int nbytes);
    bit a;
    i2c_start();
    send_byte(8'hD2, a);
    chk(a, "R1", "write address ack", 64'(a), 64'd1);
    send_byte(cmd, a);
    chk(a, "R2", "command byte ack", 64'(a), 64'd1);
    send_byte(cnt, a);
    chk(a, "R2", "count byte ack", 64'(a), 64'd1);
    for (int k = 0; k < nbytes; k++) begin
      send_byte(wdata[k], a);
      if (k < 8) begin
        chk(a, "R3", "data byte ack", 64'(a), 64'd1);
        m_store[k] = wdata[k] & bmask(k);
      end else begin
        chk(a, "R4", "extra data byte ack", 64'(a), 64'd1);
      end
    end
    i2c_stop();
    idle_window();
  endtask

  task automatic read_txn();
    bit         a;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hD3, a);
    chk(a, "R1", "read address ack", 64'(a), 64'd1);
    recv_byte(b, 1'b1);
    chk(b == 8'h08, "R5", "byte count", 64'(b), 64'h08);
    for (int k = 0; k < 8; k++) begin
      recv_byte(b, k < 7);
      chk(b == exp_byte(k), "R5", "read data byte", 64'(b), 64'(exp_byte(k)));
    end
    i2c_stop();
    wq(5);
    chk(sda_w == 1'b1, "R12", "line released after stop", 64'(sda_w), 64'd1);
    idle_window();
  endtask

  initial begin
    bit a;
    m_store[0] = 8'h00; m_store[1] = 8'h7F; m_store[2] = 8'h7F; m_store[3] = 8'h1F;
    m_store[4] = 8'h7F; m_store[5] = 8'hFF; m_store[6] = 8'h07; m_store[7] = 8'h00;
    wq(10);
    rst_n = 1'b1;
    wq(3);
    strap_i = 5'b01001;            // R7: late strap change must be ignored
    wq(10);
    idle_window();                 // R6 defaults, R7 capture, R9 strap code

    // R1: foreign address gets no ack and changes nothing
    i2c_start();
    send_byte(8'hA4, a);
    chk(!a, "R1", "foreign address nack", 64'(a), 64'd0);
    i2c_stop();
    idle_window();

    // full write, nonzero command/count contents (R2, R3, R8, R9, R10, R11)
    wdata[0] = 8'h9A; wdata[1] = 8'h00; wdata[2] = 8'h12; wdata[3] = 8'h00;
    wdata[4] = 8'h80; wdata[5] = 8'h3C; wdata[6] = 8'h11; wdata[7] = 8'hE7;
    write_txn(8'h5A, 8'h33, 8);
    read_txn();

    // overflow write (R4), strap code selected again, agp-only stop
    wdata[0] = 8'h05; wdata[1] = 8'hFF; wdata[2] = 8'hFF; wdata[3] = 8'hFF;
    wdata[4] = 8'hC0; wdata[5] = 8'h00; wdata[6] = 8'hF0; wdata[7] = 8'h0F;
    wdata[8] = 8'hAA; wdata[9] = 8'h55;
    write_txn(8'h00, 8'hFF, 10);
    read_txn();

    // partial write: two bytes only, rest must hold (R3)
    wdata[0] = 8'h4C; wdata[1] = 8'h00;
    write_txn(8'hFF, 8'h01, 2);

    // stop select 01 then 00 (R11), read-only bits under all-ones write (R8)
    wdata[0] = 8'h0A; wdata[1] = 8'h80; wdata[2] = 8'h80; wdata[3] = 8'hE0; wdata[4] = 8'h40;
    write_txn(8'h12, 8'h05, 5);
    wdata[4] = 8'h3F;
    write_txn(8'h34, 8'h05, 5);
    read_txn();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule